// File: doc/BRIEF.md
# DMA Channel Interrupt Router

This block takes the per-channel completion events of an eight-channel DMA engine and turns them into interrupt requests. There is one shared interrupt, which covers every channel that has no line of its own, and three steerable interrupts. Each steerable interrupt follows exactly one channel. There is also a separate error interrupt for DMA bus faults.

A channel bound to a steerable line is hidden from the shared line and from the shared status mask. A clear issued through the shared path cannot remove that channel's pending flag. Only an acknowledge on the line that owns the channel clears it.

Software drives the block through a one-cycle command port. Each command carries an operation code, a line number and a data word. The shared status mask is always visible as a 32-bit word.

Top module: `intr_route`

## Requirements
- R1: After reset, every interrupt output, the error interrupt and the whole status word are zero, and every line is disabled and unbound.
- R2: An `evt_i[c]` pulse sets channel c's pending flag. Bit c of `status_o` is that flag for unbound channels, and bits 8 to 31 always read zero.
- R3: Command op 1 (bind) with `cmd_line` 1 to 3 binds channel `cmd_data[2:0]` to that line and enables the line. A bind that names line 0 changes nothing.
- R4: A channel bound to any steerable line reads zero in `status_o` and does not count toward `irq_o[0]`.
- R5: `irq_o[0]` is high exactly when line 0 is enabled and `status_o` has at least one bit set.
- R6: `irq_o[k]` (k = 1..3) is high exactly when line k is enabled and bound, and its channel is pending.
- R7: Command op 4 (shared clear) clears the pending flags named in `cmd_data[7:0]`, but only for channels that are not bound. Bound channels keep their flags.
- R8: Command op 6 (acknowledge) on line 1 to 3 clears the pending flag of the channel bound to that line. An acknowledge on line 0 or on an unbound line changes nothing.
- R9: When two steerable lines are bound to the same channel, both lines fire and the channel stays hidden from the shared status.
- R10: A `bus_err_i` pulse sets the error flag, and `err_irq_o` is that flag. It stays set until command op 5 (error clear).
- R11: When an event or a bus error arrives in the same cycle as a clear of the same flag, the flag ends up set.
- R12: Command op 2 enables line `cmd_line` (0 to 3) and op 3 disables it. A disabled line's output stays low while its pending flags are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 8 | Per-channel completion event pulses |
| bus_err_i | input | 1 | DMA bus error pulse |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Operation: 0 none, 1 bind, 2 enable, 3 disable, 4 shared clear, 5 error clear, 6 acknowledge |
| cmd_line | input | 2 | Interrupt line number: 0 is shared, 1 to 3 are steerable |
| cmd_data | input | 32 | Channel number in bits 2:0, or the clear mask in bits 7:0 |
| irq_o | output | 4 | Interrupt requests: bit 0 is shared, bits 1 to 3 are steerable |
| err_irq_o | output | 1 | Error interrupt |
| status_o | output | 32 | Pending flags of the unbound channels |

## Verification
The bench targets the masking corner cases. It issues a shared clear against a bound channel, which a leaky design would lose. It acknowledges on line 0 and on unbound lines, which a careless decoder would turn into clears. It binds one channel to two lines, and a priority encoder would let only one of them fire. It also rebinds a line, after which a stale mask would keep the old channel hidden. Events that collide with clears expose a design that lets the clear win and drops a completion. A long run of random commands is checked every cycle against a bench model of the flags, bindings and enables.

// File: rtl/intr_route_pkg.sv
package intr_route_pkg;
  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_BIND      = 3'd1,
    OP_ENABLE    = 3'd2,
    OP_DISABLE   = 3'd3,
    OP_CLR_SHARE = 3'd4,
    OP_CLR_ERR   = 3'd5,
    OP_ACK       = 3'd6
  } route_op_e;
endpackage

// File: rtl/intr_route_map.sv
module intr_route_map
  import intr_route_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int NCFG = 3,
  parameter int CHW  = 3,
  parameter int LW   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic [2:0]                cmd_op,
  input  logic [LW-1:0]             cmd_line,
  input  logic [CHW-1:0]            cmd_chan,
  output logic [NCFG-1:0]           line_valid,
  output logic [NCFG-1:0][CHW-1:0]  line_chan,
  output logic [NCFG:0]             line_en,
  output logic [NCH-1:0]            bound_mask
);
  logic [NCFG-1:0]          valid_q, valid_d;
  logic [NCFG-1:0][CHW-1:0] chan_q, chan_d;
  logic [NCFG:0]            en_q, en_d;
  logic                     map_upd;
  route_op_e                op;

  assign op = route_op_e'(cmd_op);
  assign map_upd = cmd_valid && (op == OP_BIND || op == OP_ENABLE || op == OP_DISABLE);

  always_comb begin
    valid_d = valid_q;
    chan_d  = chan_q;
    en_d    = en_q;
    case (op)
      OP_BIND: begin
        for (int j = 0; j < NCFG; j++) begin
          if (cmd_line == LW'(j + 1)) begin
            valid_d[j] = 1'b1;
            chan_d[j]  = cmd_chan;
            en_d[j+1]  = 1'b1;
          end
        end
      end
      OP_ENABLE: begin
        for (int i = 0; i <= NCFG; i++)
          if (cmd_line == LW'(i)) en_d[i] = 1'b1;
      end
      OP_DISABLE: begin
        for (int i = 0; i <= NCFG; i++)
          if (cmd_line == LW'(i)) en_d[i] = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      chan_q  <= '0;
      en_q    <= '0;
    end else if (map_upd) begin
      valid_q <= valid_d;
      chan_q  <= chan_d;
      en_q    <= en_d;
    end
  end

  always_comb begin
    bound_mask = '0;
    for (int c = 0; c < NCH; c++)
      for (int j = 0; j < NCFG; j++)
        if (valid_q[j] && chan_q[j] == CHW'(c)) bound_mask[c] = 1'b1;
  end

  assign line_valid = valid_q;
  assign line_chan  = chan_q;
  assign line_en    = en_q;
endmodule

// File: rtl/intr_route_pend.sv
module intr_route_pend #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_mask,
  input  logic [NCH-1:0] clr_mask,
  input  logic           err_set,
  input  logic           err_clr,
  output logic [NCH-1:0] pend,
  output logic           err_flag
);
  logic [NCH-1:0] pend_q, pend_d;
  logic           err_q, err_d;
  logic           pend_upd, err_upd;

  assign pend_upd = |(set_mask | clr_mask);
  assign err_upd  = err_set | err_clr;

  always_comb begin
    pend_d = (pend_q & ~clr_mask) | set_mask;
    err_d  = err_set | (err_q & ~err_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (pend_upd) pend_q <= pend_d;
      if (err_upd)  err_q  <= err_d;
    end
  end

  assign pend     = pend_q;
  assign err_flag = err_q;
endmodule

// File: rtl/intr_route_out.sv
module intr_route_out #(
  parameter int NCH  = 8,
  parameter int NCFG = 3,
  parameter int CHW  = 3,
  parameter int STW  = 32
) (
  input  logic [NCH-1:0]           pend,
  input  logic [NCH-1:0]           bound_mask,
  input  logic [NCFG-1:0]          line_valid,
  input  logic [NCFG-1:0][CHW-1:0] line_chan,
  input  logic [NCFG:0]            line_en,
  output logic [NCFG:0]            irq,
  output logic [STW-1:0]           status
);
  logic [NCH-1:0] shared_pend;

  assign shared_pend = pend & ~bound_mask;
  assign status      = {{(STW-NCH){1'b0}}, shared_pend};
  assign irq[0]      = line_en[0] & (|shared_pend);

  for (genvar j = 0; j < NCFG; j++) begin : g_line
    assign irq[j+1] = line_en[j+1] & line_valid[j] & pend[line_chan[j]];
  end
endmodule

// File: rtl/intr_route.sv
module intr_route
  import intr_route_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int NCFG = 3,
  parameter int STW  = 32,
  localparam int CHW = $clog2(NCH),
  localparam int LW  = $clog2(NCFG + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  evt_i,
  input  logic            bus_err_i,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic [LW-1:0]   cmd_line,
  input  logic [STW-1:0]  cmd_data,
  output logic [NCFG:0]   irq_o,
  output logic            err_irq_o,
  output logic [STW-1:0]  status_o
);
  logic [NCFG-1:0]          line_valid;
  logic [NCFG-1:0][CHW-1:0] line_chan;
  logic [NCFG:0]            line_en;
  logic [NCH-1:0]           bound_mask;
  logic [NCH-1:0]           pend;
  logic [NCH-1:0]           clr_mask;
  logic                     err_clr;
  route_op_e                op;

  assign op      = route_op_e'(cmd_op);
  assign err_clr = cmd_valid && op == OP_CLR_ERR;

  always_comb begin
    clr_mask = '0;
    if (cmd_valid && op == OP_CLR_SHARE)
      clr_mask = cmd_data[NCH-1:0] & ~bound_mask;
    if (cmd_valid && op == OP_ACK) begin
      for (int j = 0; j < NCFG; j++)
        if (cmd_line == LW'(j + 1) && line_valid[j]) clr_mask[line_chan[j]] = 1'b1;
    end
  end

  intr_route_map #(.NCH(NCH), .NCFG(NCFG), .CHW(CHW), .LW(LW)) u_map (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_line(cmd_line), .cmd_chan(cmd_data[CHW-1:0]),
    .line_valid(line_valid), .line_chan(line_chan), .line_en(line_en),
    .bound_mask(bound_mask)
  );

  intr_route_pend #(.NCH(NCH)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_mask(evt_i), .clr_mask(clr_mask),
    .err_set(bus_err_i), .err_clr(err_clr), .pend(pend), .err_flag(err_irq_o)
  );

  intr_route_out #(.NCH(NCH), .NCFG(NCFG), .CHW(CHW), .STW(STW)) u_out (
    .pend(pend), .bound_mask(bound_mask), .line_valid(line_valid),
    .line_chan(line_chan), .line_en(line_en), .irq(irq_o), .status(status_o)
  );
endmodule

// File: rtl/intr_route_chk.sv
module intr_route_chk #(
  parameter int NCH  = 8,
  parameter int NCFG = 3,
  parameter int STW  = 32,
  parameter int CHW  = 3,
  parameter int LW   = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NCH-1:0]            evt_i,
  input logic                      bus_err_i,
  input logic                      cmd_valid,
  input logic [2:0]                cmd_op,
  input logic [LW-1:0]             cmd_line,
  input logic [NCFG:0]             irq_o,
  input logic                      err_irq_o,
  input logic [STW-1:0]            status_o,
  input logic [NCFG-1:0]           line_valid,
  input logic [NCFG-1:0][CHW-1:0]  line_chan
);
  // R5
  shared_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o[0] |-> (|status_o));

  // R10
  err_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err_i |=> err_irq_o);

  // R10
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_irq_o && !(cmd_valid && cmd_op == 3'd5)) |=> err_irq_o);

  for (genvar j = 0; j < NCFG; j++) begin : g_chk
    // R4
    bound_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_valid[j] |-> !status_o[line_chan[j]]);

    // R6
    line_needs_bind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[j+1] |-> line_valid[j]);

    // R8
    ack_drops_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd6 && cmd_line == LW'(j + 1) && line_valid[j]
       && !evt_i[line_chan[j]]) |=> !irq_o[j+1]);
  end
endmodule

bind intr_route intr_route_chk #(
  .NCH(NCH), .NCFG(NCFG), .STW(STW), .CHW(CHW), .LW(LW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_err_i(bus_err_i),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_line(cmd_line),
  .irq_o(irq_o), .err_irq_o(err_irq_o), .status_o(status_o),
  .line_valid(line_valid), .line_chan(line_chan)
);

// File: tb/intr_route_test.sv
module intr_route_test;
  logic        clk;
  logic        rst_n;
  logic [7:0]  evt_i;
  logic        bus_err_i;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [1:0]  cmd_line;
  logic [31:0] cmd_data;
  logic [3:0]  irq_o;
  logic        err_irq_o;
  logic [31:0] status_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;

  bit [7:0] m_pend;
  bit       m_err;
  bit [3:0] m_en;
  bit [2:0] m_val;
  bit [2:0] m_ch [3];

  intr_route uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_err_i(bus_err_i),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_line(cmd_line),
    .cmd_data(cmd_data), .irq_o(irq_o), .err_irq_o(err_irq_o),
    .status_o(status_o)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  function automatic bit [7:0] exp_bound();
    bit [7:0] b = '0;
    for (int j = 0; j < 3; j++) if (m_val[j]) b[m_ch[j]] = 1'b1;
    return b;
  endfunction

  function automatic bit [31:0] exp_status();
    return {24'd0, m_pend & ~exp_bound()};
  endfunction

  function automatic bit [3:0] exp_irq();
    bit [3:0] r;
    r[0] = m_en[0] & (|exp_status());
    for (int j = 0; j < 3; j++) r[j+1] = m_en[j+1] & m_val[j] & m_pend[m_ch[j]];
    return r;
  endfunction

  task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic compare_all(string tag);
    check(tag, "R2/R4 status", status_o, exp_status());
    check(tag, "R5/R6 irq", {28'd0, irq_o}, {28'd0, exp_irq()});
    check(tag, "R10 err", {31'd0, err_irq_o}, {31'd0, m_err});
  endtask

  // Applies one cycle of stimulus at a falling edge, advances the model,
  // then samples at the next falling edge.
  task automatic cycle(bit v, bit [2:0] op, bit [1:0] ln, bit [31:0] d,
                       bit [7:0] ev, bit be, string tag);
    bit [7:0] clr;
    evt_i = ev; bus_err_i = be; cmd_valid = v; cmd_op = op;
    cmd_line = ln; cmd_data = d;
    clr = '0;
    if (v && op == 3'd4) clr = d[7:0] & ~exp_bound();
    if (v && op == 3'd6 && ln != 0 && m_val[ln-1]) clr[m_ch[ln-1]] = 1'b1;
    m_pend = (m_pend & ~clr) | ev;
    if (be) m_err = 1'b1;
    else if (v && op == 3'd5) m_err = 1'b0;
    if (v && op == 3'd1 && ln != 0) begin
      m_val[ln-1] = 1'b1; m_ch[ln-1] = d[2:0]; m_en[ln] = 1'b1;
    end
    if (v && op == 3'd2) m_en[ln] = 1'b1;
    if (v && op == 3'd3) m_en[ln] = 1'b0;
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic idle(string tag);
    cycle(0, 3'd0, 2'd0, 32'd0, 8'd0, 0, tag);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; evt_i = '0; bus_err_i = 0; cmd_valid = 0;
    cmd_op = '0; cmd_line = '0; cmd_data = '0;
    m_pend = '0; m_err = 0; m_en = '0; m_val = '0;
    for (int j = 0; j < 3; j++) m_ch[j] = '0;
    repeat (3) @(negedge clk);
    compare_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1 after release");

    // shared path
    cycle(0, 3'd0, 2'd0, 32'd0, 8'h08, 0, "R12 pending while disabled");
    cycle(1, 3'd2, 2'd0, 32'd0, 8'h00, 0, "R12 enable shared");
    cycle(1, 3'd1, 2'd0, 32'd3, 8'h00, 0, "R3 bind to line 0 ignored");
    cycle(1, 3'd1, 2'd1, 32'd3, 8'h00, 0, "R3 bind ch3 to line1");
    cycle(1, 3'd4, 2'd0, 32'hFF, 8'h00, 0, "R7 shared clear spares bound");
    cycle(1, 3'd6, 2'd0, 32'd0, 8'h00, 0, "R8 ack line0 no effect");
    cycle(1, 3'd6, 2'd2, 32'd0, 8'h00, 0, "R8 ack unbound line no effect");
    cycle(1, 3'd6, 2'd1, 32'd0, 8'h00, 0, "R8 ack line1");
    // shared channel blocking
    cycle(0, 3'd0, 2'd0, 32'd0, 8'h81, 0, "R2 events ch0 ch7");
    cycle(1, 3'd4, 2'd0, 32'h01, 8'h01, 0, "R11 event beats clear");
    cycle(1, 3'd3, 2'd0, 32'd0, 8'h00, 0, "R12 disable shared");
    cycle(1, 3'd4, 2'd0, 32'h81, 8'h00, 0, "R7 shared clear");
    // dual binding
    cycle(1, 3'd1, 2'd2, 32'd5, 8'h00, 0, "R9 bind ch5 line2");
    cycle(1, 3'd1, 2'd3, 32'd5, 8'h00, 0, "R9 bind ch5 line3");
    cycle(1, 3'd2, 2'd0, 32'd0, 8'h20, 0, "R9 both fire, hidden");
    cycle(1, 3'd1, 2'd2, 32'd6, 8'h00, 0, "R3 rebind line2 to ch6");
    cycle(1, 3'd6, 2'd3, 32'd0, 8'h00, 0, "R8 ack line3");
    // error
    cycle(0, 3'd0, 2'd0, 32'd0, 8'h00, 1, "R10 bus error");
    idle("R10 error held");
    cycle(1, 3'd5, 2'd0, 32'd0, 8'h00, 1, "R11 error beats clear");
    cycle(1, 3'd5, 2'd0, 32'd0, 8'h00, 0, "R10 error clear");

    for (int i = 0; i < 3000; i++) begin
      bit [7:0] ev;
      ev = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
      cycle(($urandom % 4) != 0, 3'($urandom % 7), 2'($urandom),
            $urandom, ev, ($urandom % 16) == 0, "R4 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule